// File: doc/BRIEF.md
# Pipeline Scoreboard Bypass Controller

This block sits beside the Decode stage of an in-order pipeline and keeps, for every architectural register, the position of the youngest in-flight instruction that will write it. Execution units do not all take the same time. Simple arithmetic produces its value in the first execution stage. Memory and branch operations only have their value after the memory stage. Multiply and divide run through a fully pipelined unit of `LAT` cycles, which can forward only from its last stage.

For each source operand of the instruction in Decode, the block decides between three outcomes. The operand is read from the register file, or it is forwarded from a pipeline stage named by a 2-bit code, or the instruction is held. All forwarding paths feed the first execution stage. An advance strobe moves every tracked entry one step along its own flow. A flush strobe, raised when a mispredicted branch resolves in the memory stage, returns every entry to the register-file state.

Top module: `sb_bypass_ctrl`

## Requirements
- R1: After reset every register is in the register-file state. Every used source has `rd_rf` set, its `byp_sel` is 0, and `stall` is low.
- R2: Class code 0 (simple arithmetic; code 3 behaves the same) forwards with code 0 while the writer is in the first execution stage. After one advance it forwards with code 2 (memory stage). After two advances it forwards with code 3 (writeback). After three advances it is read from the register file.
- R3: Class code 1 (memory or branch) stalls a consumer while the writer is in the first execution stage and in the memory stage. It forwards with code 3 from writeback and is then read from the register file.
- R4: Class code 2 (long-latency unit of `LAT` cycles) stalls a consumer for the first `LAT`-1 advances after it is recorded. It then forwards with code 1 (last execution stage), then code 2, then code 3, and is then read from the register file.
- R5: While `adv` is low and `flush` is low, no entry changes state.
- R6: A destination recorded on an advancing edge enters the first execution stage on that edge and is not also moved along that same edge.
- R7: When `ZERO_REG` is 1, register 0 is never recorded. A source naming it is read from the register file and never stalls.
- R8: On an edge with `flush` high, every entry returns to the register-file state, and the destination presented on that edge is not recorded.
- R9: A new writer of a register that already has a writer in flight replaces that entry, so the entry follows the youngest writer.
- R10: A destination is recorded only on an edge where `valid` and `adv` are high and `stall` is low.
- R11: A source whose `src_use` bit is 0 never causes a stall and reports `rd_rf` 0 and `byp_sel` 0.
- R12: `stall` is high exactly when `valid` is high and at least one used source has a pending, not-yet-forwardable writer. A stalled source reports `rd_rf` 0 and `byp_sel` 0. Outputs respond in the same cycle as the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | An instruction is present in Decode |
| cls | input | 2 | Instruction class: 0 simple, 1 memory/branch, 2 long-latency, 3 simple |
| dst | input | $clog2(NREG) | Destination register of the Decode instruction |
| src0 | input | $clog2(NREG) | First source register |
| src1 | input | $clog2(NREG) | Second source register |
| src_use | input | 2 | Bit i set when source i is read |
| adv | input | 1 | Pipeline advances on this edge |
| flush | input | 1 | Misprediction flush on this edge |
| stall | output | 1 | Hold the Decode instruction |
| rd_rf | output | 2 | Bit i: source i is read from the register file |
| byp_sel | output | 4 | Bits [2i+1:2i]: forwarding code of source i (0 EXE_0, 1 EXE_N, 2 MEM, 3 WB) |

## Verification
On every clock, assertions check four things: the cycle after a flush never stalls, `stall` is never raised without `valid`, sources naming only register 0 never stall, and the long-latency stage counter stays within 1 to `LAT`-2 while inside the unit. The forwarding codes of each class are only shown by the bench's scenarios, which step each class along its flow. So are the stall window of the long-latency unit at two latencies, the youngest-writer replacement, the suppression of recording under a stall or flush, and the hold while `adv` is low.

// File: rtl/sb_bypass_ctrl.sv
module sb_bypass_ctrl #(
  parameter int NREG     = 32,
  parameter int LAT      = 4,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  logic [1:0]              cls,
  input  logic [$clog2(NREG)-1:0] dst,
  input  logic [$clog2(NREG)-1:0] src0,
  input  logic [$clog2(NREG)-1:0] src1,
  input  logic [1:0]              src_use,
  input  logic                    adv,
  input  logic                    flush,
  output logic                    stall,
  output logic [1:0]              rd_rf,
  output logic [3:0]              byp_sel
);
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(LAT) + 1;

  localparam logic [2:0] ST_RF  = 3'd0;
  localparam logic [2:0] ST_E0  = 3'd1;
  localparam logic [2:0] ST_EI  = 3'd2;
  localparam logic [2:0] ST_EN  = 3'd3;
  localparam logic [2:0] ST_MEM = 3'd4;
  localparam logic [2:0] ST_WB  = 3'd5;

  logic [2:0]    st_q  [NREG];
  logic [2:0]    rdy_q [NREG];
  logic [2:0]    nxt_q [NREG];
  logic [CW-1:0] cnt_q [NREG];

  logic [AW-1:0] srcs [2];
  logic [1:0]    sel_w [2];
  logic [1:0]    hold_w;

  assign srcs[0] = src0;
  assign srcs[1] = src1;

  logic record;
  assign record = valid && !stall && adv;

  logic [2:0] new_rdy, new_nxt;
  assign new_rdy = (cls == 2'd1) ? ST_WB : (cls == 2'd2) ? ST_EN : ST_E0;
  assign new_nxt = (cls != 2'd2) ? ST_MEM : (LAT == 2) ? ST_EN : ST_EI;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) begin
        st_q[r]  <= ST_RF;
        rdy_q[r] <= ST_RF;
        nxt_q[r] <= ST_MEM;
        cnt_q[r] <= '0;
      end
    end else if (flush) begin
      for (int r = 0; r < NREG; r++) st_q[r] <= ST_RF;
    end else if (adv) begin
      for (int r = 0; r < NREG; r++) begin
        if (record && dst == AW'(r) && !(ZERO_REG && r == 0)) begin
          st_q[r]  <= ST_E0;
          rdy_q[r] <= new_rdy;
          nxt_q[r] <= new_nxt;
          cnt_q[r] <= '0;
        end else begin
          case (st_q[r])
            ST_E0: begin
              st_q[r]  <= nxt_q[r];
              cnt_q[r] <= CW'(1);
            end
            ST_EI: begin
              if (cnt_q[r] == CW'(LAT - 2)) st_q[r] <= ST_EN;
              else cnt_q[r] <= cnt_q[r] + CW'(1);
            end
            ST_EN:   st_q[r] <= ST_MEM;
            ST_MEM:  st_q[r] <= ST_WB;
            ST_WB:   st_q[r] <= ST_RF;
            default: st_q[r] <= st_q[r];
          endcase
        end
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_src
    logic [2:0] s_st, s_rdy;
    logic       pend, fwd;
    assign s_st  = st_q[srcs[i]];
    assign s_rdy = rdy_q[srcs[i]];
    assign pend  = src_use[i] && (s_st != ST_RF);
    assign fwd   = pend && (s_st >= s_rdy);
    assign hold_w[i] = pend && !fwd;
    assign rd_rf[i]  = src_use[i] && (s_st == ST_RF);
    always_comb begin
      sel_w[i] = 2'd0;
      if (fwd) begin
        case (s_st)
          ST_EN:   sel_w[i] = 2'd1;
          ST_MEM:  sel_w[i] = 2'd2;
          ST_WB:   sel_w[i] = 2'd3;
          default: sel_w[i] = 2'd0;
        endcase
      end
    end
  end

  assign byp_sel = {sel_w[1], sel_w[0]};
  assign stall   = valid && (|hold_w);

  a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !stall);

  a_r12_stall_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> valid);

  a_r7_zero_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (ZERO_REG && valid && (!src_use[0] || src0 == '0) && (!src_use[1] || src1 == '0)) |-> !stall);

  for (genvar g = 0; g < NREG; g++) begin : g_chk
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[g] == ST_EI) |-> (cnt_q[g] >= CW'(1) && cnt_q[g] <= CW'(LAT - 2)));
  end
endmodule

// File: tb/sb_bypass_ctrl_test.sv
`timescale 1ns/1ps
module sb_bypass_ctrl_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       rst_n;
  logic       valid, adv, flush;
  logic [1:0] cls, src_use;
  logic [4:0] dst, src0, src1;
  logic       stall;
  logic [1:0] rd_rf;
  logic [3:0] byp_sel;

  sb_bypass_ctrl #(.NREG(32), .LAT(5), .ZERO_REG(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .valid(valid), .cls(cls), .dst(dst),
    .src0(src0), .src1(src1), .src_use(src_use), .adv(adv), .flush(flush),
    .stall(stall), .rd_rf(rd_rf), .byp_sel(byp_sel));

  logic       valid_b, adv_b;
  logic [1:0] cls_b, use_b;
  logic [4:0] dst_b, s0_b;
  logic       stall_b;
  logic [1:0] rd_b;
  logic [3:0] sel_b;

  sb_bypass_ctrl #(.NREG(32), .LAT(2), .ZERO_REG(1'b1)) uut_l2 (
    .clk(clk), .rst_n(rst_n), .valid(valid_b), .cls(cls_b), .dst(dst_b),
    .src0(s0_b), .src1(5'd0), .src_use(use_b), .adv(adv_b), .flush(1'b0),
    .stall(stall_b), .rd_rf(rd_b), .byp_sel(sel_b));

  // fields: valid adv flush cls dst use s0 s1 | stall rd sel
  function automatic logic [28:0] v(logic va, logic ad, logic fl, logic [1:0] c,
      logic [4:0] d, logic [1:0] u, logic [4:0] a, logic [4:0] b,
      logic es, logic [1:0] er, logic [3:0] esel);
    return {va, ad, fl, c, d, u, a, b, es, er, esel};
  endfunction

  localparam int NV = 24;
  localparam logic [28:0] VEC [NV] = '{
    v(1,0,0,0,0,3,3,4, 0,3,0),   // R1 reset state
    v(1,1,0,0,3,0,0,0, 0,0,0),   // R6 record r3 simple
    v(1,0,0,0,0,1,3,0, 0,0,0),   // R6 entered EXE_0, code 0
    v(1,0,0,0,0,1,3,0, 0,0,0),   // R5 hold without advance
    v(0,1,0,0,0,1,3,0, 0,0,0),   // R2 still code 0
    v(1,1,0,1,4,1,3,0, 0,0,2),   // R2 MEM code 2, record r4 memory class
    v(1,0,0,0,0,3,3,4, 1,0,3),   // R3 r4 in EXE_0 stalls, r3 WB code 3
    v(1,1,0,0,7,3,3,4, 1,0,3),   // R10 stalled, r7 not recorded
    v(1,1,0,0,7,3,3,4, 1,1,0),   // R3 r4 in MEM stalls, r3 back in RF
    v(0,0,0,0,0,3,7,4, 0,1,12),  // R10 r7 in RF; R3 r4 WB code 3
    v(1,1,0,2,6,3,4,0, 0,2,3),   // R7 r0 from RF; record r6 long
    v(1,1,0,0,9,1,6,0, 1,0,0),   // R4 k=0
    v(1,1,0,0,9,1,6,0, 1,0,0),   // R4 k=1
    v(1,1,0,0,9,1,6,0, 1,0,0),   // R4 k=2
    v(1,1,0,0,9,1,6,0, 1,0,0),   // R4 k=3
    v(1,1,0,0,6,1,6,0, 0,0,1),   // R4 k=4 EXE_N code 1; new r6 writer
    v(0,0,0,0,0,1,6,0, 0,0,0),   // R9 youngest writer in EXE_0
    v(1,1,1,0,8,1,6,0, 0,0,0),   // R8 flush edge
    v(1,0,0,0,0,3,6,8, 0,3,0),   // R8 all in RF, r8 not recorded
    v(1,1,0,1,5,0,0,0, 0,0,0),   // R11 record r5 memory class
    v(1,0,0,0,0,0,5,5, 0,0,0),   // R11 unused sources ignored
    v(1,0,0,0,0,2,5,5, 1,0,0),   // R12 stalled source reports zeros
    v(1,1,0,1,0,3,0,0, 0,3,0),   // R7 r0 sources, dst r0 ignored
    v(1,0,0,0,0,1,0,0, 0,1,0)    // R7 r0 still in RF
  };
  localparam int REQ [NV] = '{1,6,6,5,2,2,3,10,3,10,7,4,4,4,4,4,9,8,8,11,11,12,7,7};

  task automatic chk(string req, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: {stall,rd_rf,byp_sel} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive_b(logic va, logic ad, logic [1:0] c, logic [4:0] d, logic [4:0] s);
    valid_b = va; adv_b = ad; cls_b = c; dst_b = d; s0_b = s; use_b = 2'b01;
  endtask

  initial begin
    rst_n = 1'b0; valid = 0; adv = 0; flush = 0; cls = 0; dst = 0;
    src0 = 0; src1 = 0; src_use = 0;
    drive_b(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      logic [28:0] e;
      e = VEC[k];
      {valid, adv, flush, cls, dst, src_use, src0, src1} = e[28:7];
      #1;
      chk($sformatf("R%0d row %0d", REQ[k], k), {stall, rd_rf, byp_sel}, e[6:0]);
      @(posedge clk);
      @(negedge clk);
    end

    // R1 reset mid-run: r5 was in MEM, reset returns it to RF
    valid = 1; adv = 0; flush = 0; src_use = 2'b01; src0 = 5'd5;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset", {stall, rd_rf, byp_sel}, {1'b0, 2'b01, 4'd0});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 at LAT=2: record r2 long, then walk its flow
    drive_b(1, 1, 2'd2, 5'd2, 5'd0);
    #1;
    chk("R4 L2 record", {stall_b, rd_b, sel_b}, {1'b0, 2'b01, 4'd0});
    @(posedge clk); @(negedge clk);
    drive_b(1, 1, 2'd0, 5'd0, 5'd2);
    #1;
    chk("R4 L2 k=0 stall", {stall_b, rd_b, sel_b}, {1'b1, 2'b00, 4'd0});
    @(posedge clk); @(negedge clk);
    drive_b(0, 1, 2'd0, 5'd0, 5'd2);
    #1;
    chk("R4 L2 k=1 EXE_N", {stall_b, rd_b, sel_b}, {1'b0, 2'b00, 4'd1});
    @(posedge clk); @(negedge clk);
    #1;
    chk("R4 L2 k=2 MEM", {stall_b, rd_b, sel_b}, {1'b0, 2'b00, 4'd2});
    @(posedge clk); @(negedge clk);
    #1;
    chk("R4 L2 k=3 WB", {stall_b, rd_b, sel_b}, {1'b0, 2'b00, 4'd3});
    @(posedge clk); @(negedge clk);
    #1;
    chk("R4 L2 k=4 RF", {stall_b, rd_b, sel_b}, {1'b0, 2'b01, 4'd0});

    done = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule